// File: doc/BRIEF.md
# Program Counter and Return Stack

This block holds the instruction fetch address of a small four-phase microcontroller core. It keeps a program count of up to 13 bits, so it can address up to 8K words of 14-bit instructions. A circular return stack with 8 entries sits beside it. The core's controller drives one-cycle strobes into the block:

- advance to the next word;
- an unconditional jump or a subroutine call, each with an 11-bit literal;
- a subroutine return;
- a computed jump, made by writing the low byte of the count;
- interrupt entry.

The controller asserts the jump, call and return strobes in the second phase of an instruction and the interrupt strobe in the fourth. The block itself only reacts to strobes. Without a strobe the count does not change.

The upper address bits do not come from the counter itself. They come from a separately written high-latch register, whose value is an input here. A jump or call takes latch bits 4:3 as address bits 12:11. A low-byte write takes latch bits 4:0 as address bits 12:8. Latch bits 7:5 are never used.

When the address width is set to 8, for a program of 256 words, only the low byte matters and the latch has no effect. Interrupt entry saves the current address, moves to the vector 0x004 and gives a one-cycle pulse telling the controller to clear the global interrupt enable.

Top module: `pcu_top`

## Requirements
- R1: While rst_n is low and after its release, addr_o and low_o read 0 and gie_clr_o reads 0 until the first strobe is taken.
- R2: An advance strobe alone makes addr_o one greater after the next rising edge, wrapping from all ones (0x1FFF at width 13) to 0.
- R3: A jump strobe loads addr_o with {latch_i[4:3], lit_i[10:0]} and leaves the return stack unchanged.
- R4: A call strobe loads addr_o as a jump does and pushes the address it held before the edge onto the return stack.
- R5: A return strobe loads addr_o with the most recently pushed entry that has not been popped yet, and removes that entry.
- R6: A low-byte write loads addr_o with {latch_i[4:0], low_data_i}; low_o always shows addr_o[7:0].
- R7: An interrupt strobe pushes the current address, loads addr_o with 0x004 and raises gie_clr_o for exactly the one cycle after that edge.
- R8: The stack has 8 entries and a circular pointer: a ninth push overwrites the oldest entry, and a pop past the last entry wraps round to the newest slot.
- R9: When several strobes are high together, exactly one acts, in the priority order interrupt, return, call, jump, low-byte write, advance.
- R10: In a cycle with no strobe, addr_o and the stack stay the same.
- R11: latch_i[7:5] never affects the address. With ADDR_W = 8, the latch has no effect at all and the advance wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance strobe |
| goto_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| low_wr_i | input | 1 | Low-byte write strobe (computed jump) |
| irq_i | input | 1 | Interrupt entry strobe |
| lit_i | input | 11 | Jump or call literal |
| low_data_i | input | 8 | Data written into the low byte |
| latch_i | input | 8 | Current high-latch register value |
| addr_o | output | ADDR_W (13) | Program memory address |
| low_o | output | 8 | Readable low byte of the count |
| gie_clr_o | output | 1 | One-cycle request to clear the global interrupt enable |

## Verification
Every result is registered, so addr_o, low_o and gie_clr_o show the effect of a strobe right after the rising edge that samples it, one cycle later. A returned address appears after the same single edge, because the stack's top entry is read combinationally. The bench drives strobes on the falling edge and queues one expected item per driven cycle. Its monitor pops that item 2 ns after the next rising edge, so each comparison falls in the single cycle in which that result is due. A second instance with an 8-bit address runs from the same stimulus to cover the short-program case.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned FULL_W = 13;
    localparam int unsigned LIT_W  = 11;
    localparam int unsigned BYTE_W = 8;
    localparam logic [FULL_W-1:0] IRQ_VECTOR = 13'h004;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_LOWWR,
        OP_GOTO,
        OP_CALL,
        OP_RET,
        OP_IRQ
    } pc_op_e;

endpackage

// File: rtl/pcu_arb.sv
module pcu_arb
    import pcu_pkg::*;
(
    input  logic   step_i,
    input  logic   goto_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   low_wr_i,
    input  logic   irq_i,
    output pc_op_e op_o
);

    // R9: fixed priority, interrupt highest, advance lowest
    always_comb begin
        if (irq_i)         op_o = OP_IRQ;
        else if (ret_i)    op_o = OP_RET;
        else if (call_i)   op_o = OP_CALL;
        else if (goto_i)   op_o = OP_GOTO;
        else if (low_wr_i) op_o = OP_LOWWR;
        else if (step_i)   op_o = OP_STEP;
        else               op_o = OP_HOLD;
    end

    always_comb begin
        a_r9_one_op: assert (!(irq_i && op_o != OP_IRQ));
    end

endmodule

// File: rtl/pcu_next.sv
module pcu_next
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  pc_op_e            op_i,
    input  logic [ADDR_W-1:0] pc_q_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic [BYTE_W-1:0] low_data_i,
    input  logic [4:0]        latch_lo_i,
    input  logic [ADDR_W-1:0] pop_data_i,
    output logic [ADDR_W-1:0] pc_d_o,
    output logic              push_o,
    output logic              pop_o,
    output logic [ADDR_W-1:0] push_data_o
);

    always_comb begin
        pc_d_o      = pc_q_i;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = pc_q_i;
        unique case (op_i)
            OP_STEP:  pc_d_o = ADDR_W'(pc_q_i + 1'b1);
            OP_LOWWR: pc_d_o = ADDR_W'({latch_lo_i, low_data_i});
            OP_GOTO:  pc_d_o = ADDR_W'({latch_lo_i[4:3], lit_i});
            OP_CALL: begin
                pc_d_o = ADDR_W'({latch_lo_i[4:3], lit_i});
                push_o = 1'b1;
            end
            OP_RET: begin
                pc_d_o = pop_data_i;
                pop_o  = 1'b1;
            end
            OP_IRQ: begin
                pc_d_o = ADDR_W'(IRQ_VECTOR);
                push_o = 1'b1;
            end
            default: pc_d_o = pc_q_i;
        endcase
    end

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
    parameter int unsigned W     = 13,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] pop_data_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        sp;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] sp_inc, sp_dec;

    // R8: circular pointer, explicit wrap so any depth works
    always_comb begin
        sp_inc = (st_q.sp == LAST) ? '0 : PTR_W'(st_q.sp + 1'b1);
        sp_dec = (st_q.sp == '0) ? LAST : PTR_W'(st_q.sp - 1'b1);
    end

    assign pop_data_o = st_q.mem[sp_dec];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.sp] = push_data_i;
            st_d.sp           = sp_inc;
        end else if (pop_i) begin
            st_d.sp = sp_dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_push_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> st_q.sp == (($past(st_q.sp) == LAST) ? '0 : PTR_W'($past(st_q.sp) + 1'b1)));

    a_r8_pop_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> st_q.sp == (($past(st_q.sp) == '0) ? LAST : PTR_W'($past(st_q.sp) - 1'b1)));

    a_r8_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> pop_data_o == $past(push_data_i));

    a_r10_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(st_q.sp));

endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              goto_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              low_wr_i,
    input  logic              irq_i,
    input  logic [10:0]       lit_i,
    input  logic [7:0]        low_data_i,
    input  logic [7:0]        latch_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        low_o,
    output logic              gie_clr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              gie_clr;
    } state_t;

    state_t            st_d, st_q;
    pc_op_e            op;
    logic [ADDR_W-1:0] pc_nxt;
    logic              push, pop;
    logic [ADDR_W-1:0] push_data, pop_data;
    logic [2:0]        latch_unused;

    assign latch_unused = latch_i[7:5]; // R11: upper latch bits carry no meaning

    pcu_arb u_arb (
        .step_i   (step_i),
        .goto_i   (goto_i),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .low_wr_i (low_wr_i),
        .irq_i    (irq_i),
        .op_o     (op)
    );

    pcu_next #(.ADDR_W(ADDR_W)) u_next (
        .op_i        (op),
        .pc_q_i      (st_q.pc),
        .lit_i       (lit_i),
        .low_data_i  (low_data_i),
        .latch_lo_i  (latch_i[4:0]),
        .pop_data_i  (pop_data),
        .pc_d_o      (pc_nxt),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data)
    );

    pcu_stack #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .pop_data_o  (pop_data)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pc      = pc_nxt;
        st_d.gie_clr = (op == OP_IRQ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o    = st_q.pc;
    assign low_o     = st_q.pc[7:0];
    assign gie_clr_o = st_q.gie_clr;

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

    a_r3_goto: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_GOTO) |=> addr_o == ADDR_W'({$past(latch_i[4:3]), $past(lit_i)}));

    a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET) |=> addr_o == $past(pop_data));

    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (addr_o == ADDR_W'(IRQ_VECTOR)) && gie_clr_o);

    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie_clr_o) |-> $past(irq_i));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(addr_o) && !gie_clr_o);

endmodule

// File: tb/pcu_top_tb.sv
module pcu_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 0, goto_i = 0, call_i = 0, ret_i = 0, low_wr_i = 0, irq_i = 0;
    logic [10:0] lit_i = '0;
    logic [7:0]  low_data_i = '0, latch_i = '0;
    logic [12:0] addr_o;
    logic [7:0]  low_o, addr_s, low_s;
    logic        gie_clr_o, gie_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pcu_top u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .goto_i(goto_i), .call_i(call_i),
        .ret_i(ret_i), .low_wr_i(low_wr_i), .irq_i(irq_i), .lit_i(lit_i),
        .low_data_i(low_data_i), .latch_i(latch_i),
        .addr_o(addr_o), .low_o(low_o), .gie_clr_o(gie_clr_o)
    );

    pcu_top #(.ADDR_W(8)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .goto_i(goto_i), .call_i(call_i),
        .ret_i(ret_i), .low_wr_i(low_wr_i), .irq_i(irq_i), .lit_i(lit_i),
        .low_data_i(low_data_i), .latch_i(latch_i),
        .addr_o(addr_s), .low_o(low_s), .gie_clr_o(gie_s)
    );

    // reference model: index 0 is the 13-bit unit, index 1 the 8-bit unit
    logic [12:0] m_pc  [2];
    logic [12:0] m_stk [2][8];
    int          m_sp  [2];

    logic [12:0] q_big[$];
    logic [12:0] q_small[$];
    bit          q_gie[$];
    string       q_tag[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input bit st, input bit gt, input bit cl, input bit rt,
                         input bit lw, input bit iq, input logic [10:0] lit,
                         input logic [7:0] dat, input logic [7:0] lat, input string tag);
        @(negedge clk);
        step_i = st; goto_i = gt; call_i = cl; ret_i = rt; low_wr_i = lw; irq_i = iq;
        lit_i = lit; low_data_i = dat; latch_i = lat;
        for (int k = 0; k < 2; k++) begin
            logic [12:0] mask;
            mask = (k == 0) ? 13'h1FFF : 13'h00FF;
            if (iq) begin
                m_stk[k][m_sp[k]] = m_pc[k]; m_sp[k] = (m_sp[k] + 1) % 8;
                m_pc[k] = 13'h004 & mask;
            end else if (rt) begin
                m_sp[k] = (m_sp[k] + 7) % 8;
                m_pc[k] = m_stk[k][m_sp[k]];
            end else if (cl) begin
                m_stk[k][m_sp[k]] = m_pc[k]; m_sp[k] = (m_sp[k] + 1) % 8;
                m_pc[k] = {lat[4:3], lit} & mask;
            end else if (gt) begin
                m_pc[k] = {lat[4:3], lit} & mask;
            end else if (lw) begin
                m_pc[k] = {lat[4:0], dat} & mask;
            end else if (st) begin
                m_pc[k] = (m_pc[k] + 13'd1) & mask;
            end
        end
        q_big.push_back(m_pc[0]);
        q_small.push_back(m_pc[1]);
        q_gie.push_back(iq);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, '0, '0, '0, tag);
    endtask

    // monitor: result of a strobe is due just after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q_big.size() > 0) begin
                logic [12:0] eb, es;
                bit          eg;
                string       t;
                eb = q_big.pop_front();
                es = q_small.pop_front();
                eg = q_gie.pop_front();
                t  = q_tag.pop_front();
                check(addr_o == eb, t, "addr", int'(addr_o), int'(eb));
                check(low_o == eb[7:0], {t, "/R6"}, "low_o", int'(low_o), int'(eb[7:0]));
                check(addr_s == es[7:0], {t, "/R11"}, "small addr", int'(addr_s), int'(es));
                check(gie_clr_o == eg && gie_s == eg, {t, "/R7"}, "gie_clr",
                      int'(gie_clr_o), int'(eg));
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_pc[k] = '0; m_sp[k] = 0;
            for (int j = 0; j < 8; j++) m_stk[k][j] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(addr_o == 0 && addr_s == 0, "R1", "reset addr", int'(addr_o), 0);
        check(low_o == 0 && gie_clr_o == 0, "R1", "reset low/gie", int'({low_o, gie_clr_o}), 0);
        rst_n = 1'b1;
        idle("R1");
        // R2: advance
        repeat (3) drive(1, 0, 0, 0, 0, 0, '0, '0, '0, "R2");
        // R6/R11: low write, bits 7:5 of latch ignored, small wraps
        drive(0, 0, 0, 0, 1, 0, '0, 8'hFF, 8'hE5, "R6");
        drive(1, 0, 0, 0, 0, 0, '0, '0, 8'hE5, "R11");
        // R2: wrap at top of the 13-bit space
        drive(0, 0, 0, 0, 1, 0, '0, 8'hFF, 8'h1F, "R6");
        drive(1, 0, 0, 0, 0, 0, '0, '0, '0, "R2");
        // R3: jump
        drive(0, 1, 0, 0, 0, 0, 11'h123, '0, 8'h18, "R3");
        idle("R10");
        // R4/R5: call then return
        drive(0, 0, 1, 0, 0, 0, 11'h456, '0, 8'h08, "R4");
        drive(1, 0, 0, 0, 0, 0, '0, '0, '0, "R2");
        drive(0, 0, 0, 1, 0, 0, '0, '0, '0, "R5");
        // R8: nine nested calls then nine returns
        for (int n = 1; n <= 9; n++)
            drive(0, 0, 1, 0, 0, 0, 11'(n * 16 + 1), '0, 8'h10, "R8");
        for (int n = 0; n < 9; n++)
            drive(0, 0, 0, 1, 0, 0, '0, '0, '0, "R8");
        // R7: interrupt entry, pulse lasts one cycle, return resumes
        drive(0, 1, 0, 0, 0, 0, 11'h2AA, '0, 8'h00, "R3");
        drive(0, 0, 0, 0, 0, 1, '0, '0, '0, "R7");
        idle("R7");
        idle("R10");
        drive(0, 0, 0, 1, 0, 0, '0, '0, '0, "R5");
        // R9: priority
        drive(1, 1, 1, 1, 1, 1, 11'h077, 8'h33, 8'h1F, "R9");
        drive(1, 1, 1, 1, 1, 0, 11'h077, 8'h33, 8'h1F, "R9");
        drive(1, 1, 1, 0, 1, 0, 11'h155, 8'h33, 8'h08, "R9");
        drive(1, 1, 0, 0, 1, 0, 11'h066, 8'h33, 8'h10, "R9");
        drive(1, 0, 0, 0, 1, 0, '0, 8'h44, 8'h02, "R9");
        drive(0, 0, 0, 1, 0, 0, '0, '0, '0, "R9");
        // R10: no strobe, latch and data move but count holds
        drive(0, 0, 0, 0, 0, 0, 11'h7FF, 8'hAA, 8'hFF, "R10");
        idle("R10");
        repeat (3) @(negedge clk);
        check(q_big.size() == 0, "R10", "queue drained", q_big.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule